// File: doc/BRIEF.md
# Interrupt Cause Register Controller

This block gathers interrupt events from a network port into one cause register and drives a single interrupt line to the host. Receive write-back or a receive descriptor threshold event sets the receive-queue bit. Transmit write-back sets the transmit-queue bit. Several housekeeping conditions share one summary "other" bit. A mask register decides which pending causes reach the line. Software enables mask bits through a set address and disables them through a clear address. An auto-mask register names mask bits to drop automatically when a pending interrupt is acknowledged by a read.

Software reaches all state through a plain register port. The port accepts a request in every cycle, so there is no back-pressure. Read data returns one cycle later with a valid strobe. A cause read may clear the register and may apply the auto-mask, depending on the mask contents and on the summary pending bit. A write of 1 to a cause bit clears that bit. A throttle timer, counted in ticks of a clock prescaler, sets a minimum spacing between successive assertions of the line.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, every register (cause, mask, auto-mask, throttle) reads as zero. The interrupt line and the read-valid strobe are low.
- R2: An event sets its cause bit on the next clock edge. Receive write-back or receive threshold sets bit 20. Transmit write-back sets bit 22. Any of the five "other" events sets bit 24. Every other bit from 0 to 30 always reads 0.
- R3: Bit 31 of a cause read is 1 exactly when some cause bit is set. Writing 0 or 1 to bit 31 has no effect.
- R4: A write to the cause address clears each implemented bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R5: An event that arrives in the same cycle as a clear of its bit, by a write or by a clearing read, keeps the bit set.
- R6: A write to offset 1 ORs the data into the mask, limited to implemented bits. A write to offset 2 clears the mask bits whose data bit is 1. A read of offset 1 or 2 returns the mask.
- R7: With throttling idle, the interrupt line is high in the cycle after the edge on which (cause AND mask) becomes non-zero. It falls on the edge on which (cause AND mask) becomes zero.
- R8: A cause read while the mask is all zeros clears the whole cause register.
- R9: Auto-mask is active when the auto-mask register (offset 3) is non-zero. A cause read while bit 31 is 1 and auto-mask is active clears the cause register and clears the mask bits set in the auto-mask register.
- R10: A cause read while bit 31 is 0 changes neither the cause register nor the mask.
- R11: A cause read while bit 31 is 1, the mask is non-zero and the auto-mask register is zero changes neither the cause register nor the mask.
- R12: The throttle register (offset 4) stores data bits 15:0, and bits 31:16 read as 0. A value of zero disables throttling.
- R13: With throttle interval I and prescaler TICK_DIV, two rising edges of the interrupt line are at least I*TICK_DIV+1 cycles apart. When a masked cause is pending throughout, the gap is exactly that.
- R14: A read (req=1, we=0) produces rvalid=1 one cycle later. The read data is the register's value before that read's side effects. Offsets: 0 cause, 1 mask-set, 2 mask-clear, 3 auto-mask, 4 throttle. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_rx_wb | input | 1 | Receive queue write-back event |
| ev_rx_thresh | input | 1 | Receive descriptor threshold event |
| ev_tx_wb | input | 1 | Transmit queue write-back event |
| ev_other | input | N_OTHER | Link change, overrun, management access done, small packet, ACK frame events |
| reg_req | input | 1 | Register access request, accepted in every cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid when reg_rvalid is high |
| reg_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| irq_out | output | 1 | Interrupt line to the host |

## Verification
The bench builds the block with TICK_DIV=4 and keeps the other defaults. With TICK_DIV=4, a throttle interval of 3 holds the line off for 13 cycles, so the exact gap between two assertions can be measured in a short run. The 32-bit default width leaves the summary bit at position 31, and the bench checks that bit against its write-ignore and read-clear rules.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_MSET  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_MCLR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_AUTO  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_THROT = 3'd4;
endpackage

// File: rtl/irq_cause_bits.sv
module irq_cause_bits #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ev_vec,
  input  logic [DATA_W-1:0] clr_vec,
  input  logic              clr_all,
  output logic [DATA_W-1:0] cause_q,
  output logic [DATA_W-1:0] cause_d
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    if (IMPL[g]) begin : g_live
      logic bit_q;
      logic bit_d;
      // a new event outranks any clear arriving in the same cycle
      assign bit_d = ev_vec[g] | (bit_q & ~(clr_vec[g] | clr_all));
      always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign cause_q[g] = bit_q;
      assign cause_d[g] = bit_d;
    end else begin : g_resv
      assign cause_q[g] = 1'b0;
      assign cause_d[g] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              auto_we,
  input  logic              auto_apply,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] mask_d,
  output logic [DATA_W-1:0] auto_q
);
  always_comb begin
    mask_d = mask_q;
    if (set_we)     mask_d = mask_d | (wdata & IMPL);
    if (clr_we)     mask_d = mask_d & ~wdata;
    if (auto_apply) mask_d = mask_d & ~auto_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      auto_q <= '0;
    end else begin
      mask_q <= mask_d;
      if (auto_we) auto_q <= wdata & IMPL;
    end
  end
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int THR_W    = 16,
  parameter int TICK_DIV = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_wdata,
  input  logic             want,
  output logic [THR_W-1:0] thr_q,
  output logic             irq_q
);
  logic [THR_W-1:0] cnt_q;
  logic             irq_d;
  logic             rise;
  logic             tick;

  assign irq_d = want && (irq_q || (cnt_q == '0));
  assign rise  = irq_d && !irq_q;

  if (TICK_DIV > 1) begin : g_pre
    localparam int PRE_W = $clog2(TICK_DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    logic [PRE_W-1:0] pre_q;
    assign tick = (pre_q == PRE_LAST);
    always_ff @(posedge clk) begin
      if (!rst_n)                pre_q <= '0;
      else if (rise || tick)     pre_q <= '0;
      else if (cnt_q != '0)      pre_q <= pre_q + 1'b1;
    end
  end else begin : g_nopre
    assign tick = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (thr_we) thr_q <= thr_wdata;
      if (rise)                         cnt_q <= thr_q;
      else if (tick && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int RX_BIT    = 20,
  parameter int TX_BIT    = 22,
  parameter int OTHER_BIT = 24,
  parameter int N_OTHER   = 5,
  parameter int THR_W     = 16,
  parameter int TICK_DIV  = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_rx_wb,
  input  logic               ev_rx_thresh,
  input  logic               ev_tx_wb,
  input  logic [N_OTHER-1:0] ev_other,
  input  logic               reg_req,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  output logic               irq_out
);
  localparam int SUM_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] IMPL =
    (DATA_W'(1) << RX_BIT) | (DATA_W'(1) << TX_BIT) | (DATA_W'(1) << OTHER_BIT);

  logic [DATA_W-1:0] ev_vec, cause_q, cause_d, mask_q, mask_d, auto_q;
  logic [DATA_W-1:0] clr_vec, rd_mux, cause_view;
  logic [THR_W-1:0]  thr_q;
  logic              summary, wr_en, rd_en, cause_rd, auto_act;
  logic              clr_all, auto_apply, want;

  always_comb begin
    ev_vec            = '0;
    ev_vec[RX_BIT]    = ev_rx_wb | ev_rx_thresh;
    ev_vec[TX_BIT]    = ev_tx_wb;
    ev_vec[OTHER_BIT] = |ev_other;
  end

  assign wr_en    = reg_req && reg_we;
  assign rd_en    = reg_req && !reg_we;
  assign cause_rd = rd_en && (reg_addr == OFS_CAUSE);
  assign summary  = |cause_q;
  assign auto_act = (auto_q != '0);

  assign clr_vec    = (wr_en && reg_addr == OFS_CAUSE) ? reg_wdata : '0;
  assign clr_all    = cause_rd && ((mask_q == '0) || (summary && auto_act));
  assign auto_apply = cause_rd && summary && auto_act;

  irq_cause_bits #(.DATA_W(DATA_W), .IMPL(IMPL)) u_bits (
    .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec), .clr_vec(clr_vec),
    .clr_all(clr_all), .cause_q(cause_q), .cause_d(cause_d)
  );

  irq_mask_regs #(.DATA_W(DATA_W), .IMPL(IMPL)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_en && reg_addr == OFS_MSET),
    .clr_we(wr_en && reg_addr == OFS_MCLR),
    .auto_we(wr_en && reg_addr == OFS_AUTO),
    .auto_apply(auto_apply), .wdata(reg_wdata),
    .mask_q(mask_q), .mask_d(mask_d), .auto_q(auto_q)
  );

  assign want = |(cause_d & mask_d);

  irq_throttle #(.THR_W(THR_W), .TICK_DIV(TICK_DIV)) u_thr (
    .clk(clk), .rst_n(rst_n),
    .thr_we(wr_en && reg_addr == OFS_THROT),
    .thr_wdata(reg_wdata[THR_W-1:0]),
    .want(want), .thr_q(thr_q), .irq_q(irq_out)
  );

  always_comb begin
    cause_view          = cause_q;
    cause_view[SUM_BIT] = summary;
    case (reg_addr)
      OFS_CAUSE:          rd_mux = cause_view;
      OFS_MSET, OFS_MCLR: rd_mux = mask_q;
      OFS_AUTO:           rd_mux = auto_q;
      OFS_THROT:          rd_mux = DATA_W'(thr_q);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= rd_en;
      if (rd_en) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
  import irq_cause_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int THR_W    = 16,
  parameter int TICK_DIV = 13,
  parameter logic [DATA_W-1:0] IMPL = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              reg_rvalid,
  input logic              irq_out,
  input logic [DATA_W-1:0] cause_q,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] auto_q,
  input logic [THR_W-1:0]  thr_q,
  input logic [DATA_W-1:0] ev_vec
);
  logic              irq_prev, seen_rise;
  logic [31:0]       gap;
  logic [THR_W-1:0]  thr_prev, thr_snap;
  logic [ADDR_W-1:0] addr_prev;
  logic              rise, sum_now, cause_rd;

  assign rise     = irq_out && !irq_prev;
  assign sum_now  = |cause_q;
  assign cause_rd = reg_req && !reg_we && (reg_addr == OFS_CAUSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev  <= 1'b0;
      seen_rise <= 1'b0;
      gap       <= '0;
      thr_prev  <= '0;
      thr_snap  <= '0;
      addr_prev <= '0;
    end else begin
      irq_prev  <= irq_out;
      thr_prev  <= thr_q;
      addr_prev <= reg_addr;
      if (rise) begin
        seen_rise <= 1'b1;
        gap       <= 32'd1;
        thr_snap  <= thr_prev;
      end else if (gap != '1) begin
        gap <= gap + 32'd1;
      end
    end
  end

  p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid && addr_prev == OFS_CAUSE |-> (reg_rdata[DATA_W-2:0] & ~IMPL[DATA_W-2:0]) == '0);

  p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cause_q & $past(ev_vec)) == $past(ev_vec));

  p_summary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid && addr_prev == OFS_CAUSE |-> reg_rdata[DATA_W-1] == (|reg_rdata[DATA_W-2:0]));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_we && reg_addr == OFS_CAUSE |=> (cause_q & $past(reg_wdata) & ~$past(ev_vec)) == '0);

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (cause_q & mask_q) != '0);

  p_mask0_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cause_rd && mask_q == '0 |=> cause_q == $past(ev_vec));

  p_auto_apply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cause_rd && sum_now && auto_q != '0 && !reg_we |=> (mask_q & $past(auto_q)) == '0);

  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cause_rd && !sum_now |=> mask_q == $past(mask_q));

  p_rvalid_r14: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_we |=> reg_rvalid);

  p_throttle_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rise && seen_rise |-> gap >= (32'(thr_snap) * TICK_DIV + 32'd1));
endmodule

bind irq_cause_ctrl irq_cause_chk #(
  .DATA_W(DATA_W), .THR_W(THR_W), .TICK_DIV(TICK_DIV), .IMPL(IMPL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .reg_rvalid(reg_rvalid), .irq_out(irq_out), .cause_q(cause_q),
  .mask_q(mask_q), .auto_q(auto_q), .thr_q(thr_q), .ev_vec(ev_vec)
);

// File: tb/irq_cause_ctrl_bench.sv
module irq_cause_ctrl_bench;
  localparam int TICK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_rx_wb = 0, ev_rx_thresh = 0, ev_tx_wb = 0;
  logic [4:0]  ev_other = '0;
  logic        reg_req = 0, reg_we = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid, irq_out;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_cause_ctrl #(.TICK_DIV(TICK)) u_irq_cause_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_rx_wb(ev_rx_wb), .ev_rx_thresh(ev_rx_thresh),
    .ev_tx_wb(ev_tx_wb), .ev_other(ev_other), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        rx, rxt, tx;
    logic [4:0]  oth;
    logic        req, we;
    logic [2:0]  addr;
    logic [31:0] wd;
    logic        eirq, erv;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1,0,0,5'd0, 0,0,3'd0,32'h0,        0,0,32'h0},        // R2 rx event
    '{4'd6,  0,0,0,5'd0, 1,1,3'd1,32'h0140_0000,0,0,32'h0},        // R6 mask set
    '{4'd7,  0,0,1,5'd0, 0,0,3'd0,32'h0,        1,0,32'h0},        // R7 tx event raises line
    '{4'd11, 0,0,0,5'd0, 1,0,3'd0,32'h0,        1,1,32'h8050_0000},// R11 read, no auto
    '{4'd4,  0,0,0,5'd0, 1,1,3'd0,32'h0040_0000,0,0,32'h0},        // R4 clear bit22, R7 drop
    '{4'd6,  0,0,0,5'd0, 1,0,3'd1,32'h0,        0,1,32'h0140_0000},// R6 mask read
    '{4'd6,  0,0,0,5'd0, 1,1,3'd2,32'h0100_0000,0,0,32'h0},        // R6 mask clear
    '{4'd9,  0,0,0,5'd0, 1,1,3'd3,32'h0040_0000,0,0,32'h0},        // R9 auto write
    '{4'd2,  0,0,0,5'd4, 0,0,3'd0,32'h0,        0,0,32'h0},        // R2 other event
    '{4'd7,  0,0,0,5'd0, 1,1,3'd1,32'h0010_0000,1,0,32'h0},        // R7 mask opens bit20
    '{4'd9,  0,0,0,5'd0, 1,0,3'd0,32'h0,        0,1,32'h8110_0000},// R9 read with auto
    '{4'd10, 0,0,0,5'd0, 1,0,3'd0,32'h0,        0,1,32'h0},        // R10 idle read
    '{4'd10, 0,0,0,5'd0, 1,0,3'd1,32'h0,        0,1,32'h0010_0000},// R10 mask kept, R9 applied
    '{4'd5,  0,0,1,5'd0, 1,1,3'd0,32'hFFFF_FFFF,0,0,32'h0},        // R5 event beats write
    '{4'd5,  1,0,0,5'd0, 1,0,3'd0,32'h0,        1,1,32'h8040_0000},// R5 event beats read clear
    '{4'd6,  0,0,0,5'd0, 1,1,3'd2,32'hFFFF_FFFF,0,0,32'h0},        // R6 clear all mask
    '{4'd8,  0,0,0,5'd0, 1,0,3'd0,32'h0,        0,1,32'h8010_0000},// R8 read, mask zero
    '{4'd8,  0,0,0,5'd0, 1,0,3'd0,32'h0,        0,1,32'h0},        // R8 cleared
    '{4'd4,  0,1,0,5'd0, 1,1,3'd0,32'h0,        0,0,32'h0},        // R4 write 0, R2 threshold
    '{4'd3,  0,0,0,5'd0, 1,1,3'd0,32'h8000_0000,0,0,32'h0},        // R3 bit31 write
    '{4'd3,  0,0,0,5'd0, 1,0,3'd0,32'h0,        0,1,32'h8010_0000},// R3 bit31 unaffected
    '{4'd12, 0,0,0,5'd0, 1,1,3'd4,32'hABCD_0012,0,0,32'h0},        // R12 throttle write
    '{4'd12, 0,0,0,5'd0, 1,0,3'd4,32'h0,        0,1,32'h0000_0012},// R12 upper reads 0
    '{4'd12, 0,0,0,5'd0, 1,1,3'd4,32'h0,        0,0,32'h0}         // R12 disable
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rx, input logic rxt, input logic tx, input logic [4:0] oth,
                       input logic req, input logic we, input logic [2:0] addr,
                       input logic [31:0] wd);
    ev_rx_wb = rx; ev_rx_thresh = rxt; ev_tx_wb = tx; ev_other = oth;
    reg_req = req; reg_we = we; reg_addr = addr; reg_wdata = wd;
    @(negedge clk);
    ev_rx_wb = 0; ev_rx_thresh = 0; ev_tx_wb = 0; ev_other = '0;
    reg_req = 0; reg_we = 0;
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary_and_end();
  end

  initial begin
    int t_first, t_second;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 irq", 32'(irq_out), 32'h0);
    chk("R1 rvalid", 32'(reg_rvalid), 32'h0);
    for (int a = 0; a < 5; a++) begin
      drive(0,0,0,5'd0, 1,0,3'(a),32'h0);
      chk("R1 reg", reg_rdata, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].rx, VEC[i].rxt, VEC[i].tx, VEC[i].oth,
            VEC[i].req, VEC[i].we, VEC[i].addr, VEC[i].wd);
      n_cmp++;
      if (irq_out !== VEC[i].eirq) begin
        n_bad++;
        $display("FAIL R%0d vec %0d irq: actual %b expected %b", VEC[i].rq, i, irq_out, VEC[i].eirq);
      end
      chk("R14 rvalid", 32'(reg_rvalid), 32'(VEC[i].erv));
      if (VEC[i].erv) begin
        n_cmp++;
        if (reg_rdata !== VEC[i].erd) begin
          n_bad++;
          $display("FAIL R%0d vec %0d rdata: actual %h expected %h", VEC[i].rq, i, reg_rdata, VEC[i].erd);
        end
      end
    end

    // R14: unmapped offset reads 0
    drive(0,0,0,5'd0, 1,0,3'd7,32'h0);
    chk("R14 unmapped", reg_rdata, 32'h0);

    // R13: throttle interval 3 with TICK 4 gives a 13-cycle gap
    drive(0,0,0,5'd0, 1,1,3'd1,32'h0040_0000);
    drive(0,0,0,5'd0, 1,1,3'd4,32'h0000_0003);
    drive(0,0,1,5'd0, 0,0,3'd0,32'h0);
    chk("R13 first rise", 32'(irq_out), 32'h1);
    t_first = cyc;
    drive(0,0,0,5'd0, 1,1,3'd0,32'h0040_0000);
    chk("R13 cleared", 32'(irq_out), 32'h0);
    t_second = -1;
    for (int k = 0; k < 40 && t_second < 0; k++) begin
      drive(0,0,1,5'd0, 0,0,3'd0,32'h0);
      if (irq_out) t_second = cyc;
    end
    chk("R13 gap", 32'(t_second - t_first), 32'(3*TICK+1));
    drive(0,0,0,5'd0, 1,1,3'd4,32'h0);
    drive(0,0,0,5'd0, 1,1,3'd2,32'hFFFF_FFFF);
    drive(0,0,0,5'd0, 1,0,3'd0,32'h0);

    // R2: each other event sets bit 24 alone
    for (int b = 0; b < 5; b++) begin
      drive(0,0,0,5'(1 << b), 0,0,3'd0,32'h0);
      drive(0,0,0,5'd0, 1,0,3'd0,32'h0);
      chk("R2 other", reg_rdata, 32'h8100_0000);
    end

    summary_and_end();
  end
endmodule